// File: doc/BRIEF.md
# Cartridge Bank-Switching Memory Mapper

This block sits between an 8-bit CPU with a 16-bit address bus and three memories: a banked cartridge ROM outside the block, a cartridge RAM and a console work RAM, both held inside it. Every CPU access is decoded into one of these targets. For a ROM read the block drives a physical ROM address made of a 6-bit bank number and a 14-bit offset. The bank comes from one of three slot registers. The bottom kilobyte is the exception and always reads bank 0, so interrupt vectors stay reachable whatever mapping is in place.

The CPU sets the slot banks and a cartridge-RAM control byte by writing the four highest addresses. Those addresses also lie in the mirrored work RAM, and every such write is stored there as well, so reading them back returns the last byte written. When cartridge RAM is enabled, the third slot window becomes a read/write view of one 16 KB half of the cartridge RAM. The control byte picks which half.

Both RAM depths are parameters. The defaults are small so the block elaborates quickly. A full-size build sets `WRAM_AW` to 13 and `CRAM_AW` to 15. With smaller depths, the upper address bits inside each window alias. A RAM location that has not been written since reset reads as 0xFF.

Top module: `cart_mapper`

## Requirements
- R1: After reset, slot k (k = 0, 1, 2) maps ROM bank k and cartridge RAM is unmapped. Every work-RAM and cartridge-RAM location reads 0xFF until it is written. `cpu_rvalid` and `wr_ack` are low.
- R2: A read at 0x0000–0x03FF drives `rom_addr` = {6'd0, addr[13:0]}, whatever the slot 0 register holds.
- R3: A read at 0x0400–0x3FFF, 0x4000–0x7FFF or 0x8000–0xBFFF (the last only while cartridge RAM is unmapped) drives `rom_addr` = {bank of slot 0/1/2, addr[13:0]} and returns `rom_rdata` sampled in that cycle.
- R4: A write to 0xFFFD, 0xFFFE or 0xFFFF loads bank register 0, 1 or 2 with wdata[5:0]. The very next access uses the new bank.
- R5: A write to 0xFFFC sets the cartridge-RAM enable from wdata bit 3 and the half select from wdata bit 2 (1 = upper 16 KB half).
- R6: Work RAM answers reads and writes at 0xC000–0xFFFF, with 0xE000–0xFFFF mirroring 0xC000–0xDFFF. Writes to 0xFFFC–0xFFFF are also stored there and read back.
- R7: While cartridge RAM is enabled, reads and writes at 0x8000–0xBFFF reach location {half, addr[CRAM_AW-2:0]} of cartridge RAM. The two halves hold independent data.
- R8: One cycle after any write, `wr_ack` pulses. `wr_ok` is 1 for writes to work RAM or to mapped cartridge RAM and 0 for every other write below 0xC000. A rejected write changes no storage.
- R9: Read data appears on `cpu_rdata` one cycle after `cpu_rd`, qualified by a one-cycle `cpu_rvalid`. A cycle with `cpu_rd` and `cpu_wr` both high performs only the write and produces no `cpu_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read request this cycle |
| cpu_wr | input | 1 | Write request this cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data valid strobe |
| wr_ack | output | 1 | A write completed last cycle |
| wr_ok | output | 1 | That write was accepted |
| rom_addr | output | 20 | Physical ROM address, {bank, offset} |
| rom_rdata | input | 8 | ROM data for rom_addr, same cycle |

## Verification
The hardest state to reach is a cartridge-RAM half that holds data written while the other half was selected. Reaching it needs a control write, a slot-2 write, a second control write and a slot-2 read in the right order. Writes to 0xFFFC–0xFFFF are mixed often enough into the random stream that the enable and half-select toggle many times between slot-2 accesses. Directed sequences additionally fill both halves and read them back across a switch. A further directed sequence points slot 0 at a high bank and probes both sides of the 0x0400 boundary.

// File: rtl/cart_mapper_pkg.sv
// Shared types and fixed address-map constants for the cartridge mapper.
// Assumes a 16-bit CPU address bus and an 8-bit data bus.
package cart_mapper_pkg;
    typedef enum logic [1:0] {
        TGT_ROM  = 2'd0,
        TGT_WRAM = 2'd1,
        TGT_CRAM = 2'd2
    } tgt_e;

    localparam int unsigned NUM_SLOTS   = 3;
    localparam int unsigned OFS_W       = 14;          // 16 KB window offset
    localparam logic [15:0] CTRL_ADDR   = 16'hFFFC;    // cartridge-RAM control
    localparam logic [15:0] BANK_BASE   = 16'hFFFD;    // slot 0 bank register
    localparam logic [15:0] PIN_LIMIT   = 16'h0400;    // pinned-to-bank-0 region
endpackage

// File: rtl/mapper_regs.sv
// Mapping registers: three slot bank numbers and the cartridge-RAM control.
// Assumes BANK_W <= 8. Updates take effect on the clock edge of the write.
module mapper_regs
    import cart_mapper_pkg::*;
#(
    parameter int unsigned BANK_W = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [15:0]                     addr,
    input  logic [7:0]                      wdata,
    output logic [NUM_SLOTS-1:0][BANK_W-1:0] bank,
    output logic                            cram_on,
    output logic                            cram_hi
);
    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
            localparam logic [15:0] MY_ADDR = BANK_BASE + 16'(g);
            // Load bank register g on a write to its address; reset to bank g.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank[g] <= BANK_W'(g);
                else if (wr_en && addr == MY_ADDR)
                    bank[g] <= wdata[BANK_W-1:0];
            end
        end
    endgenerate

    // Capture enable (bit 3) and half select (bit 2) from control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cram_on <= 1'b0;
            cram_hi <= 1'b0;
        end else if (wr_en && addr == CTRL_ADDR) begin
            cram_on <= wdata[3];
            cram_hi <= wdata[2];
        end
    end

    a_r4_bank2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 16'hFFFF) |=> (bank[2] == $past(wdata[BANK_W-1:0])));
    a_r5_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 16'hFFFC) |=> (cram_on == $past(wdata[3]) && cram_hi == $past(wdata[2])));
endmodule

// File: rtl/mapper_decode.sv
// Combinational address decode: picks the target for the access and forms
// the physical ROM address and the RAM indices. Assumes CRAM_AW >= 2.
module mapper_decode
    import cart_mapper_pkg::*;
#(
    parameter int unsigned BANK_W  = 6,
    parameter int unsigned WRAM_AW = 11,
    parameter int unsigned CRAM_AW = 12
) (
    input  logic [15:0]                      addr,
    input  logic [NUM_SLOTS-1:0][BANK_W-1:0] bank,
    input  logic                             cram_on,
    input  logic                             cram_hi,
    output tgt_e                             tgt,
    output logic [BANK_W+OFS_W-1:0]          rom_addr,
    output logic [WRAM_AW-1:0]               wram_idx,
    output logic [CRAM_AW-1:0]               cram_idx
);
    localparam int unsigned HALF_AW = CRAM_AW - 1;

    logic [BANK_W-1:0] sel_bank;

    // Choose the target memory from the top two address bits and the enable.
    always_comb begin
        if (addr[15:14] == 2'b11)
            tgt = TGT_WRAM;
        else if (addr[15:14] == 2'b10 && cram_on)
            tgt = TGT_CRAM;
        else
            tgt = TGT_ROM;
    end

    // Pick the ROM bank: pinned bank 0 for the bottom kilobyte, else the slot.
    always_comb begin
        if (addr < PIN_LIMIT)
            sel_bank = '0;
        else if (addr[15:14] == 2'b00)
            sel_bank = bank[0];
        else if (addr[15:14] == 2'b01)
            sel_bank = bank[1];
        else
            sel_bank = bank[2];
    end

    assign rom_addr = {sel_bank, addr[OFS_W-1:0]};
    assign wram_idx = addr[WRAM_AW-1:0];
    assign cram_idx = {cram_hi, addr[HALF_AW-1:0]};
endmodule

// File: rtl/mapper_ram.sv
// Byte RAM with a synchronous read port and a per-location written flag.
// Unwritten locations read 0xFF, which stands in for a power-up fill.
// Assumes read and write are never requested in the same cycle.
module mapper_ram #(
    parameter int unsigned AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] idx,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] written;

    // Store write data; the array itself is never reset.
    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    // Track which locations hold written data since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            written <= '0;
        else if (we)
            written[idx] <= 1'b1;
    end

    // Registered read; an unwritten location returns the fill value.
    always_ff @(posedge clk) begin
        if (re)
            rdata <= written[idx] ? mem[idx] : 8'hFF;
    end
endmodule

// File: rtl/cart_mapper.sv
// Top of the cartridge mapper. Decodes CPU accesses, owns the mapping
// registers, work RAM and cartridge RAM, drives the banked ROM address and
// returns registered read data. Assumes the ROM answers in the same cycle.
module cart_mapper
    import cart_mapper_pkg::*;
#(
    parameter int unsigned BANK_W  = 6,
    parameter int unsigned WRAM_AW = 11,
    parameter int unsigned CRAM_AW = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [15:0]             cpu_addr,
    input  logic                    cpu_rd,
    input  logic                    cpu_wr,
    input  logic [7:0]              cpu_wdata,
    output logic [7:0]              cpu_rdata,
    output logic                    cpu_rvalid,
    output logic                    wr_ack,
    output logic                    wr_ok,
    output logic [BANK_W+OFS_W-1:0] rom_addr,
    input  logic [7:0]              rom_rdata
);
    logic [NUM_SLOTS-1:0][BANK_W-1:0] bank;
    logic                             cram_on, cram_hi;
    tgt_e                             tgt, tgt_q;
    logic [WRAM_AW-1:0]               wram_idx;
    logic [CRAM_AW-1:0]               cram_idx;
    logic [7:0]                       wram_q, cram_q, rom_q;
    logic                             rd_go;

    assign rd_go = cpu_rd && !cpu_wr;

    mapper_regs #(.BANK_W(BANK_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .addr(cpu_addr),
        .wdata(cpu_wdata), .bank(bank), .cram_on(cram_on), .cram_hi(cram_hi)
    );

    mapper_decode #(.BANK_W(BANK_W), .WRAM_AW(WRAM_AW), .CRAM_AW(CRAM_AW)) u_dec (
        .addr(cpu_addr), .bank(bank), .cram_on(cram_on), .cram_hi(cram_hi),
        .tgt(tgt), .rom_addr(rom_addr), .wram_idx(wram_idx), .cram_idx(cram_idx)
    );

    mapper_ram #(.AW(WRAM_AW)) u_wram (
        .clk(clk), .rst_n(rst_n),
        .we(cpu_wr && tgt == TGT_WRAM), .re(rd_go && tgt == TGT_WRAM),
        .idx(wram_idx), .wdata(cpu_wdata), .rdata(wram_q)
    );

    mapper_ram #(.AW(CRAM_AW)) u_cram (
        .clk(clk), .rst_n(rst_n),
        .we(cpu_wr && tgt == TGT_CRAM), .re(rd_go && tgt == TGT_CRAM),
        .idx(cram_idx), .wdata(cpu_wdata), .rdata(cram_q)
    );

    // Remember the read target and capture ROM data for the return cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q      <= TGT_ROM;
            rom_q      <= 8'h00;
            cpu_rvalid <= 1'b0;
        end else begin
            cpu_rvalid <= rd_go;
            if (rd_go) begin
                tgt_q <= tgt;
                rom_q <= rom_rdata;
            end
        end
    end

    // Report each write one cycle later, accepted only for RAM targets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ack <= 1'b0;
            wr_ok  <= 1'b0;
        end else begin
            wr_ack <= cpu_wr;
            wr_ok  <= cpu_wr && tgt != TGT_ROM;
        end
    end

    // Select the returned byte by the target latched with the read.
    always_comb begin
        case (tgt_q)
            TGT_WRAM: cpu_rdata = wram_q;
            TGT_CRAM: cpu_rdata = cram_q;
            default:  cpu_rdata = rom_q;
        endcase
    end

    a_r9_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr) |=> cpu_rvalid);
    a_r9_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd && !cpu_wr) |=> !cpu_rvalid);
    a_r8_ack_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |=> (wr_ack && $past(cpu_wr)));
    a_r8_rom_write_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr < 16'h8000) |=> !wr_ok);
    a_r2_pinned_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h0400) |-> (rom_addr[BANK_W+OFS_W-1:OFS_W] == '0));
endmodule

// File: tb/tb_cart_mapper.sv
module tb_cart_mapper;
    localparam int WA = 11;
    localparam int CA = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_rvalid, wr_ack, wr_ok;
    logic [19:0] rom_addr;
    logic [7:0]  rom_rdata;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    logic [7:0] wram_m [1<<WA];
    logic [7:0] cram_m [1<<CA];
    logic [5:0] bank_m [3];
    logic       con_m, chi_m;

    always #2 clk = ~clk;

    function automatic logic [7:0] rom_byte(input logic [19:0] pa);
        return pa[7:0] ^ {pa[19:14], 2'b10} ^ pa[13:6];
    endfunction

    assign rom_rdata = rom_byte(rom_addr);

    cart_mapper dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_rvalid(cpu_rvalid), .wr_ack(wr_ack), .wr_ok(wr_ok),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata)
    );

    function automatic logic [19:0] exp_phys(input logic [15:0] a);
        if (a < 16'h0400) return {6'd0, a[13:0]};
        return {bank_m[a[15:14]], a[13:0]};
    endfunction

    function automatic logic is_rom(input logic [15:0] a);
        return (a[15:14] != 2'b11) && !(a[15:14] == 2'b10 && con_m);
    endfunction

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        if (a[15:14] == 2'b11) return wram_m[a[WA-1:0]];
        if (a[15:14] == 2'b10 && con_m) return cram_m[{chi_m, a[CA-2:0]}];
        return rom_byte(exp_phys(a));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        if (is_rom(a)) check({req, " rom_addr"}, 32'(rom_addr), 32'(exp_phys(a)));
        e = exp_read(a);
        @(negedge clk);
        cpu_rd = 1'b0;
        check({req, " R9 rvalid"}, 32'(cpu_rvalid), 1);
        check({req, " data"}, 32'(cpu_rdata), 32'(e));
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d, output logic ok);
        ok = 1'b0;
        if (a[15:14] == 2'b11) begin
            wram_m[a[WA-1:0]] = d; ok = 1'b1;
            if (a == 16'hFFFC) begin con_m = d[3]; chi_m = d[2]; end
            else if (a >= 16'hFFFD) bank_m[a - 16'hFFFD] = d[5:0];
        end else if (a[15:14] == 2'b10 && con_m) begin
            cram_m[{chi_m, a[CA-2:0]}] = d; ok = 1'b1;
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic also_rd);
        logic ok;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = also_rd;
        model_write(a, d, ok);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        check("R8 wr_ack", 32'(wr_ack), 1);
        check("R8 wr_ok", 32'(wr_ok), 32'(ok));
        if (also_rd) check("R9 no rvalid on rd+wr", 32'(cpu_rvalid), 0);
    endtask

    function automatic logic [15:0] rand_addr();
        case ($urandom % 8)
            0: return 16'($urandom % 16'h0400);
            1: return 16'h0400 + 16'($urandom % 16'h3C00);
            2: return 16'h4000 + 16'($urandom % 16'h4000);
            3, 4: return 16'h8000 + 16'($urandom % 16'h4000);
            5: return 16'hC000 + 16'($urandom % 16'h2000);
            6: return 16'hE000 + 16'($urandom % 16'h1FFC);
            default: return 16'hFFFC + 16'($urandom % 4);
        endcase
    endfunction

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < (1<<WA); i++) wram_m[i] = 8'hFF;
        for (int i = 0; i < (1<<CA); i++) cram_m[i] = 8'hFF;
        for (int i = 0; i < 3; i++) bank_m[i] = 6'(i);
        con_m = 1'b0; chi_m = 1'b0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rvalid idle", 32'(cpu_rvalid), 0);
        check("R1 wr_ack idle", 32'(wr_ack), 0);
        do_read(16'h4123, "R1 slot1 bank1");
        do_read(16'h8456, "R1 slot2 bank2 unmapped");
        do_read(16'h0500, "R1 slot0 bank0");
        do_read(16'hC010, "R1 wram fill FF");
        do_read(16'hFFFC, "R1 ctrl shadow FF");

        // R2 / R4: pinned kilobyte vs slot 0 after remap
        do_write(16'hFFFD, 8'hC5, 1'b0);            // bank 5, upper bits dropped
        do_read(16'h03FF, "R2 pinned last byte");
        do_read(16'h0000, "R2 pinned first byte");
        do_read(16'h0400, "R4 slot0 new bank");
        do_read(16'hFFFD, "R6 shadow bank0");
        do_write(16'hFFFF, 8'h3F, 1'b0);
        do_read(16'hBFFF, "R4 R3 slot2 bank63");

        // R8: writes to ROM rejected
        do_write(16'h1234, 8'h55, 1'b0);
        do_write(16'h9000, 8'h66, 1'b0);            // unmapped cram
        do_read(16'h9000, "R8 unmapped slot2 still ROM");

        // R5 / R7: both cram halves hold independent data
        do_write(16'hFFFC, 8'h08, 1'b0);            // map, lower half
        do_read(16'h8010, "R7 cram lower unwritten FF");
        do_write(16'h8010, 8'hA1, 1'b0);
        do_write(16'hFFFC, 8'h0C, 1'b0);            // upper half
        do_read(16'h8010, "R5 R7 cram upper separate");
        do_write(16'h8010, 8'hB2, 1'b0);
        do_write(16'hFFFC, 8'h08, 1'b0);
        do_read(16'h8010, "R7 cram lower retained");
        do_write(16'hFFFC, 8'h04, 1'b0);            // unmap
        do_read(16'h8010, "R5 unmapped reads ROM");

        // R6: mirror
        do_write(16'hC123, 8'h77, 1'b0);
        do_read(16'hE123, "R6 mirror read");
        do_write(16'hF00F, 8'h88, 1'b0);
        do_read(16'hD00F, "R6 mirror write");

        // R9: read and write together
        do_write(16'hC200, 8'h42, 1'b1);
        do_read(16'hC200, "R9 rd+wr wrote");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            a = rand_addr();
            if ($urandom % 2) do_write(a, 8'($urandom), 1'b0);
            else do_read(a, "R3 R6 R7 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule